// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge and Receive-Buffer Timing

This block is the datapath and event logic for the I2C personality of a shared synchronous serial unit. It takes the SCL and SDA bus lines, removes short glitches, and detects start and stop conditions. It counts SCL pulses within a byte, shifts eight data bits in MSB first, and samples the acknowledge bit on the rising edge of the ninth pulse. It also decides when the received byte moves from the shift register into the receive buffer. In the same frame it drives the bit to be sent on its own SDA output. That output changes a fixed delay after each falling SCL edge, so data never moves near a clock edge.

Two static controls pick the behaviour. The event-select input chooses between acknowledge/no-acknowledge pulses and transmit/receive pulses. The clock-delay input enables a split buffer transfer in the ninth clock: a first load with a rotated layout on the falling edge before the ninth pulse, and a second load with the acknowledge bit on its rising edge. While the unit is disabled, the SDA output follows a preset level, the bit position is cleared and no events are raised. Clock generation, arbitration and the register interface belong to surrounding logic.

Top module: `i2c_byte_engine`

## Requirements
- R1: Each bus input passes a two-stage synchronizer and then a saturating filter. A level that differs from the filtered value for fewer than FILT_CYC consecutive system cycles (50 cycles by default, i.e. 200 ns at 4 ns) is ignored. A level that persists well beyond that is adopted.
- R2: While enabled, SDA falling with SCL high gives a one-cycle pulse on start_o. SDA rising with SCL high gives a one-cycle pulse on stop_o.
- R3: With evt_sel_i = 0, on the rising edge of the ninth SCL pulse, ack_o pulses for one cycle if SDA is low and nack_o pulses if SDA is high. rx_evt_o and tx_evt_o stay low.
- R4: With evt_sel_i = 0, the buffer is loaded at that same rising edge. rx_buf_o[7:0] holds the byte (first received bit in bit 7) and rx_buf_o[8] holds the sampled acknowledge bit. rd_byte_o equals the byte.
- R5: With evt_sel_i = 1 and clk_dly_i = 0, on the falling SCL edge that ends the eighth pulse, rx_evt_o pulses and the buffer becomes {1'b0, byte}. The buffer does not change at the ninth rising edge, and ack_o and nack_o stay low.
- R6: With evt_sel_i = 1 and clk_dly_i = 0, tx_evt_o pulses on the falling SCL edge after the ninth pulse, exactly four SCL quarter-phases later than rx_evt_o under the bench's symmetric timing.
- R7: With evt_sel_i = 1 and clk_dly_i = 1, the first load happens on the falling edge that ends the eighth pulse. It writes received bits 1 to 7 to rx_buf_o[6:0], bit 8 to rx_buf_o[8] and 0 to rx_buf_o[7]. While this layout is held, rd_byte_o returns {rx_buf_o[6:0], rx_buf_o[8]}, which is the received byte.
- R8: With evt_sel_i = 1 and clk_dly_i = 1, tx_evt_o pulses in the same cycle as rx_evt_o. A second load at the ninth rising edge writes {ack bit, byte}, and rd_byte_o returns rx_buf_o[7:0] again.
- R9: sda_o changes SDA_DLY_CYC cycles after each filtered SCL falling edge, not before. After the fall that follows k rising edges of the byte, it carries tx_data bit 7-k for k < 8, ack_drv_i for k = 8, and 1 (released) for k = 9.
- R10: With en_i low, sda_o follows sda_preset_i one cycle later, no event output pulses and the bit position is cleared. Reset leaves sda_o high and rx_buf_o at zero.
- R11: A start or stop condition resets the bit position, so a byte that follows a repeated start inside a partial byte is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enabled in I2C mode |
| evt_sel_i | input | 1 | 0: ack/nack events, 1: transmit/receive events |
| clk_dly_i | input | 1 | Split buffer transfer in ninth clock |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_preset_i | input | 1 | SDA output level while disabled |
| ack_drv_i | input | 1 | Level driven during the ninth bit |
| tx_load_i | input | 1 | Load tx_data_i into the transmit shifter |
| tx_data_i | input | 8 | Byte to transmit |
| sda_o | output | 1 | SDA output level |
| rx_buf_o | output | 9 | Raw receive buffer |
| rd_byte_o | output | 8 | Byte as returned by a read of the buffer |
| ack_o | output | 1 | Acknowledge detected pulse |
| nack_o | output | 1 | No-acknowledge detected pulse |
| rx_evt_o | output | 1 | Receive event pulse |
| tx_evt_o | output | 1 | Transmit event pulse |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |

## Verification
The bench sweeps bytes through all three event/delay combinations. Around the ninth clock it checks which edge loaded the buffer and what layout that load left. A design that loads on the wrong edge, or skips the rotation of the first split load, shows a wrong snapshot at the receive event or a wrong read view. It measures the gap between receive and transmit events, which separates a transmit event at the ninth rising or falling edge from one after the ninth pulse. It checks sda_o both before and after the output delay on every falling edge, which catches a missing delay and off-by-one bit ordering. A 30-cycle glitch on SCL inside a byte, glitches on SDA while SCL is high, and a repeated start in a partial byte each expose a filter that passes short pulses or a bit counter that is not cleared by start.

// File: rtl/i2c_engine_pkg.sv
package i2c_engine_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned POS_W  = $clog2(DATA_W + 2);

  typedef logic [POS_W-1:0] bit_pos_t;

  // bit position after k rising edges of the byte
  localparam bit_pos_t ACK_POS  = bit_pos_t'(DATA_W);
  localparam bit_pos_t POST_POS = bit_pos_t'(DATA_W + 1);

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } line_evt_t;
endpackage

// File: rtl/i2c_glitch_filt.sv
module i2c_glitch_filt #(
  parameter int unsigned THR_CYC     = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(THR_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sy;

  assign sy = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  // saturating mismatch counter: adopt new level only after THR_CYC cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else if (sy == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(THR_CYC - 1)) begin
      cnt_q  <= '0;
      filt_o <= sy;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(THR_CYC));

  p_flip_after_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> $past(sy) == filt_o);
endmodule

// File: rtl/i2c_line_events.sv
module i2c_line_events
  import i2c_engine_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      scl_i,
  input  logic      sda_i,
  output line_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      evt_o <= '0;
    end else begin
      scl_q          <= scl_i;
      sda_q          <= sda_i;
      evt_o.scl_rise <= en_i & scl_i & ~scl_q;
      evt_o.scl_fall <= en_i & ~scl_i & scl_q;
      evt_o.start    <= en_i & scl_i & scl_q & sda_q & ~sda_i;
      evt_o.stop     <= en_i & scl_i & scl_q & ~sda_q & sda_i;
    end
  end

  p_evt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));

  p_start_needs_scl_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.start |-> $past(scl_i) && !$past(sda_i));
endmodule

// File: rtl/i2c_shift_core.sv
module i2c_shift_core
  import i2c_engine_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_sel_i,
  input  logic              clk_dly_i,
  input  logic              sda_i,
  input  line_evt_t         evt_i,
  output bit_pos_t          bit_pos_o,
  output logic [DATA_W:0]   rx_buf_o,
  output logic              split_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              rx_evt_o,
  output logic              tx_evt_o
);
  logic [DATA_W-1:0] rx_sr_q;
  bit_pos_t          pos_q;

  assign bit_pos_o = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      rx_sr_q  <= '0;
      rx_buf_o <= '0;
      split_o  <= 1'b0;
      ack_o    <= 1'b0;
      nack_o   <= 1'b0;
      rx_evt_o <= 1'b0;
      tx_evt_o <= 1'b0;
    end else begin
      ack_o    <= 1'b0;
      nack_o   <= 1'b0;
      rx_evt_o <= 1'b0;
      tx_evt_o <= 1'b0;
      if (!en_i || evt_i.start || evt_i.stop) begin
        pos_q <= '0;
      end else if (evt_i.scl_rise) begin
        if (pos_q < ACK_POS) begin
          rx_sr_q <= {rx_sr_q[DATA_W-2:0], sda_i};
          pos_q   <= pos_q + 1'b1;
        end else if (pos_q == ACK_POS) begin
          pos_q <= POST_POS;
          if (!evt_sel_i) begin
            ack_o    <= ~sda_i;
            nack_o   <= sda_i;
            rx_buf_o <= {sda_i, rx_sr_q};
            split_o  <= 1'b0;
          end else if (clk_dly_i) begin
            // second transfer of the split load
            rx_buf_o <= {sda_i, rx_sr_q};
            split_o  <= 1'b0;
          end
        end
      end else if (evt_i.scl_fall) begin
        if (pos_q == ACK_POS && evt_sel_i) begin
          rx_evt_o <= 1'b1;
          tx_evt_o <= clk_dly_i;
          if (clk_dly_i) begin
            // first transfer: bits 1..7 -> [6:0], bit 8 -> [8]
            rx_buf_o <= {rx_sr_q[0], 1'b0, rx_sr_q[DATA_W-1:1]};
            split_o  <= 1'b1;
          end else begin
            rx_buf_o <= {1'b0, rx_sr_q};
            split_o  <= 1'b0;
          end
        end else if (pos_q == POST_POS) begin
          pos_q    <= '0;
          tx_evt_o <= evt_sel_i & ~clk_dly_i;
        end
      end
    end
  end

  p_ack_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || nack_o) |-> !$past(evt_sel_i) && $past(evt_i.scl_rise));

  p_rxtx_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_o || tx_evt_o) |-> $past(evt_sel_i) && $past(evt_i.scl_fall));

  p_buf_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_buf_o) |-> $past(evt_i.scl_rise || evt_i.scl_fall));

  p_pos_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POST_POS);

  p_cond_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.start || evt_i.stop || !en_i) |=> pos_q == '0);

  p_second_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i.scl_rise && pos_q == ACK_POS && evt_sel_i && clk_dly_i) |=> !split_o);
endmodule

// File: rtl/i2c_sda_drv.sv
module i2c_sda_drv
  import i2c_engine_pkg::*;
#(
  parameter int unsigned DLY_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_preset_i,
  input  logic              ack_drv_i,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              scl_fall_i,
  input  bit_pos_t          bit_pos_i,
  output logic              sda_o
);
  localparam int unsigned DW = $clog2(DLY_CYC + 1);
  localparam int unsigned IW = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sr_q;
  logic [DW-1:0]     cnt_q;
  logic              pend_q, nxt_q, nxt_bit;

  always_comb begin
    if (bit_pos_i < ACK_POS)       nxt_bit = tx_sr_q[IW'(DATA_W - 1) - bit_pos_i[IW-1:0]];
    else if (bit_pos_i == ACK_POS) nxt_bit = ack_drv_i;
    else                           nxt_bit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_sr_q <= '0;
    else if (tx_load_i) tx_sr_q <= tx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_o  <= 1'b1;
      pend_q <= 1'b0;
      nxt_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (!en_i) begin
      sda_o  <= sda_preset_i;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (scl_fall_i) begin
      nxt_q  <= nxt_bit;
      pend_q <= 1'b1;
      cnt_q  <= DW'(DLY_CYC - 1);
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        sda_o  <= nxt_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_sda_after_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_o) && $past(en_i)) |-> $past(pend_q) && $past(cnt_q) == '0);

  p_sda_preset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sda_o == $past(sda_preset_i));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_engine_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned FILT_NS       = 200,
  parameter int unsigned SDA_DLY_CYC   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              evt_sel_i,
  input  logic              clk_dly_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sda_preset_i,
  input  logic              ack_drv_i,
  input  logic              tx_load_i,
  input  logic [7:0]        tx_data_i,
  output logic              sda_o,
  output logic [8:0]        rx_buf_o,
  output logic [7:0]        rd_byte_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              rx_evt_o,
  output logic              tx_evt_o,
  output logic              start_o,
  output logic              stop_o
);
  localparam int unsigned FILT_CYC = (FILT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned N_LINES  = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  line_evt_t          evt;
  bit_pos_t           bit_pos;
  logic               split;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_glitch_filt #(.THR_CYC(FILT_CYC), .SYNC_STAGES(2)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  i2c_line_events u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .scl_i (filt_lines[0]),
    .sda_i (filt_lines[1]),
    .evt_o (evt)
  );

  // sda sampled one cycle late to line up with the registered edge
  logic sda_d_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_d_q <= 1'b1;
    else         sda_d_q <= filt_lines[1];
  end

  i2c_shift_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .evt_sel_i(evt_sel_i),
    .clk_dly_i(clk_dly_i),
    .sda_i    (sda_d_q),
    .evt_i    (evt),
    .bit_pos_o(bit_pos),
    .rx_buf_o (rx_buf_o),
    .split_o  (split),
    .ack_o    (ack_o),
    .nack_o   (nack_o),
    .rx_evt_o (rx_evt_o),
    .tx_evt_o (tx_evt_o)
  );

  i2c_sda_drv #(.DLY_CYC(SDA_DLY_CYC)) u_sda (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .sda_preset_i(sda_preset_i),
    .ack_drv_i   (ack_drv_i),
    .tx_load_i   (tx_load_i),
    .tx_data_i   (tx_data_i),
    .scl_fall_i  (evt.scl_fall),
    .bit_pos_i   (bit_pos),
    .sda_o       (sda_o)
  );

  assign start_o   = evt.start;
  assign stop_o    = evt.stop;
  assign rd_byte_o = split ? {rx_buf_o[6:0], rx_buf_o[8]} : rx_buf_o[7:0];

  p_no_evt_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !(start_o || stop_o));

  p_read_view_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_o && $past(clk_dly_i) |-> rd_byte_o == {rx_buf_o[6:0], rx_buf_o[8]});
endmodule

// File: tb/tb_i2c_byte_engine.sv
module tb_i2c_byte_engine;
  localparam int Q = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, evt_sel = 1'b0, clk_dly = 1'b0;
  logic scl = 1'b1, sda = 1'b1, sda_preset = 1'b1, ack_drv = 1'b1, tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_o, ack_o, nack_o, rx_evt_o, tx_evt_o, start_o, stop_o;
  logic [8:0] rx_buf_o;
  logic [7:0] rd_byte_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_ack = 0, n_nack = 0, n_rx = 0, n_tx = 0, n_start = 0, n_stop = 0;
  int t_rx = 0, t_tx = 0;
  logic [8:0] cap_rx_buf = '0, cap_ack_buf = '0;
  logic [7:0] cap_rd = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_byte_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .evt_sel_i(evt_sel), .clk_dly_i(clk_dly),
    .scl_i(scl), .sda_i(sda), .sda_preset_i(sda_preset), .ack_drv_i(ack_drv),
    .tx_load_i(tx_load), .tx_data_i(tx_data), .sda_o(sda_o), .rx_buf_o(rx_buf_o),
    .rd_byte_o(rd_byte_o), .ack_o(ack_o), .nack_o(nack_o), .rx_evt_o(rx_evt_o),
    .tx_evt_o(tx_evt_o), .start_o(start_o), .stop_o(stop_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_o)    n_ack++;
      if (nack_o)   n_nack++;
      if (start_o)  n_start++;
      if (stop_o)   n_stop++;
      if (ack_o || nack_o) cap_ack_buf = rx_buf_o;
      if (rx_evt_o) begin n_rx++; t_rx = cyc; cap_rx_buf = rx_buf_o; cap_rd = rd_byte_o; end
      if (tx_evt_o) begin n_tx++; t_tx = cyc; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_out(input int p, input logic [7:0] txd, input logic ackd);
    if (p < 8)  return txd[7-p];
    if (p == 8) return ackd;
    return 1'b1;
  endfunction

  task automatic bus_start(input logic [7:0] txd, input bit do_chk);
    sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
    if (do_chk) chk("R9 first bit after start", sda_o, txd[7]);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b1; tick(Q);
  endtask

  // one SCL pulse; p = pulse index within the byte
  task automatic clk_bit(input logic b, input bit glitch, input int p,
                         input logic [7:0] txd, input logic ackd, input bit do_chk);
    sda = b; tick(Q);
    scl = 1'b1;
    if (glitch) begin
      tick(Q / 2); scl = 1'b0; tick(30); scl = 1'b1; tick(2*Q - Q/2 - 30);
    end else begin
      tick(2*Q);
    end
    scl = 1'b0;
    tick(58);
    if (do_chk) chk("R9 output held during delay", sda_o, exp_out(p-1, txd, ackd));
    tick(Q - 58);
    if (do_chk) chk("R9 output after delay", sda_o, exp_out(p, txd, ackd));
  endtask

  task automatic run_byte(input logic sel, input logic dly, input logic [7:0] data,
                          input logic ack, input logic [7:0] txd, input int glitch_bit);
    int s_ack, s_nack, s_rx, s_tx, s_start, s_stop;
    evt_sel = sel; clk_dly = dly; tx_data = txd; ack_drv = ~ack;
    tx_load = 1'b1; tick(1); tx_load = 1'b0;
    s_ack = n_ack; s_nack = n_nack; s_rx = n_rx; s_tx = n_tx; s_start = n_start; s_stop = n_stop;
    bus_start(txd, 1'b1);
    for (int p = 1; p <= 8; p++) clk_bit(data[8-p], p == glitch_bit, p, txd, ~ack, 1'b1);
    clk_bit(ack, 1'b0, 9, txd, ~ack, 1'b1);
    if (!sel) begin
      chk("R3 ack count", n_ack - s_ack, {31'd0, ~ack});
      chk("R3 nack count", n_nack - s_nack, {31'd0, ack});
      chk("R3 rx/tx silent", (n_rx - s_rx) + (n_tx - s_tx), 0);
      chk("R4 buffer at ack edge", cap_ack_buf, {ack, data});
      chk("R4 buffer held", rx_buf_o, {ack, data});
      chk("R4 read view", rd_byte_o, data);
    end else if (!dly) begin
      chk("R5 rx count", n_rx - s_rx, 1);
      chk("R5 ack/nack silent", (n_ack - s_ack) + (n_nack - s_nack), 0);
      chk("R5 buffer at rx event", cap_rx_buf, {1'b0, data});
      chk("R5 buffer not reloaded", rx_buf_o, {1'b0, data});
      chk("R6 tx count", n_tx - s_tx, 1);
      chk("R6 tx after ninth pulse", t_tx - t_rx, 4*Q);
    end else begin
      chk("R7 first load layout", cap_rx_buf, {data[0], 1'b0, data[7:1]});
      chk("R7 read view of split load", cap_rd, data);
      chk("R8 second load", rx_buf_o, {ack, data});
      chk("R8 read view after second load", rd_byte_o, data);
      chk("R8 tx count", n_tx - s_tx, 1);
      chk("R8 tx with rx", t_tx - t_rx, 0);
    end
    bus_stop();
    chk("R2 start pulse", n_start - s_start, 1);
    chk("R2 stop pulse", n_stop - s_stop, 1);
  endtask

  initial begin
    int s_start, s_stop;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R10 reset sda", sda_o, 1'b1);
    chk("R10 reset buffer", rx_buf_o, 9'h000);
    chk("R10 reset read view", rd_byte_o, 8'h00);

    // disabled: preset drives output, conditions ignored
    sda_preset = 1'b0; tick(3);
    chk("R10 preset low", sda_o, 1'b0);
    s_start = n_start; s_stop = n_stop;
    sda = 1'b0; tick(Q); sda = 1'b1; tick(Q);
    chk("R10 no events while disabled", (n_start - s_start) + (n_stop - s_stop), 0);
    sda_preset = 1'b1; tick(3);
    chk("R10 preset high", sda_o, 1'b1);

    en = 1'b1; tick(Q);
    chk("R10 preset held on enable", sda_o, 1'b1);

    // sweep over modes and data patterns
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 4; i++) begin
        d = 8'(8'h1F * (i + 1) + m * 37);
        run_byte(m != 0, m == 2, d, i[0], ~d ^ 8'(i * 17), 0);
      end
    end
    run_byte(1'b0, 1'b0, 8'h00, 1'b1, 8'hFF, 0);
    run_byte(1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 0);
    run_byte(1'b1, 1'b1, 8'h01, 1'b1, 8'hA5, 0);

    // R1: SCL glitch inside a high phase must not count a bit
    run_byte(1'b1, 1'b0, 8'hB4, 1'b0, 8'h3C, 3);
    run_byte(1'b0, 1'b0, 8'h4B, 1'b0, 8'hC3, 6);

    // R1: short SDA glitch with SCL high is rejected, long pulse accepted
    s_start = n_start; s_stop = n_stop;
    sda = 1'b0; tick(30); sda = 1'b1; tick(Q);
    chk("R1 short glitch rejected", (n_start - s_start) + (n_stop - s_stop), 0);
    sda = 1'b0; tick(80); sda = 1'b1; tick(Q);
    chk("R1 long pulse gives start", n_start - s_start, 1);
    chk("R1 long pulse gives stop", n_stop - s_stop, 1);

    // R11: repeated start in a partial byte restarts bit counting
    evt_sel = 1'b0; clk_dly = 1'b0; ack_drv = 1'b1;
    bus_start(8'h00, 1'b0);
    for (int p = 1; p <= 3; p++) clk_bit(1'b0, 1'b0, p, 8'h00, 1'b1, 1'b0);
    d = 8'h6D;
    bus_start(8'h00, 1'b0);
    for (int p = 1; p <= 8; p++) clk_bit(d[8-p], 1'b0, p, 8'h00, 1'b1, 1'b0);
    clk_bit(1'b0, 1'b0, 9, 8'h00, 1'b1, 1'b0);
    chk("R11 byte after repeated start", rx_buf_o, {1'b0, d});
    bus_stop();

    // R10: disabling returns output to preset
    en = 1'b0; sda_preset = 1'b0; tick(3);
    chk("R10 preset after disable", sda_o, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule